// File: doc/BRIEF.md
# Ones-Complement Accumulator Execute Unit

This unit carries out one accumulator instruction per clock on a 16-bit accumulator held in ones-complement form. Each operation takes a 15-bit memory word, an operation code and a flag telling whether that word came from read-only (fixed) or writable (erasable) storage. The unit then registers the new accumulator, an optional memory write-back word with its enable, and an overflow status.

The accumulator has one bit more than a memory word. Its two top bits act as a pair of sign bits. When they disagree the accumulator holds an overflowed value. That value is kept as a state, not raised as an event. A chain of additions therefore still ends on the correct total as long as no partial sum grows past twice a word's range. Memory operands are widened by copying their sign bit into the extra top position. Sums use an end-around carry.

Five operations are provided: add, subtract, load-complement, bitwise AND and exchange. Exchange writes the old accumulator back to memory only when the operand address is erasable. The written word keeps the accumulator's leftmost bit as its sign. For a fixed address, exchange works as a plain load.

Top module: `oc_acc_unit`

## Requirements
- R1: After a synchronous active-high reset, `acc_q` is 0, and `ovf`, `wb_en` and `res_valid` are 0.
- R2: Opcode 0 (add) sets the accumulator to the ones-complement sum of the accumulator and the sign-extended operand. The operand's bit 14 is copied into bit 15, and the sum uses an end-around carry.
- R3: Opcode 1 (subtract) sets the accumulator to the accumulator plus the bitwise inverse of the sign-extended operand, with an end-around carry.
- R4: Opcode 2 (load-complement) sets the accumulator to the bitwise inverse of the sign-extended operand.
- R5: Opcode 3 (AND) sets the accumulator to the bitwise AND of the accumulator and the sign-extended operand.
- R6: Opcode 4 (exchange) with `addr_fixed`=1 loads the sign-extended operand into the accumulator and leaves `wb_en` at 0.
- R7: Opcode 4 with `addr_fixed`=0 loads the sign-extended operand and pulses `wb_en` for the result cycle. In that cycle `wb_word` bit 14 is the old accumulator bit 15, and `wb_word` bits 13..0 are the old accumulator bits 13..0.
- R8: `ovf` equals accumulator bit 15 XOR bit 14 after every operation. A chain of additions whose partial sums overflow still ends on the exact total.
- R9: Opcodes 5 to 7, and cycles without `op_valid`, leave the accumulator unchanged and keep `wb_en` at 0.
- R10: `res_valid` is high for exactly the cycle after each cycle in which `op_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 0 add, 1 subtract, 2 load-complement, 3 AND, 4 exchange, 5-7 no-op |
| mem_word | input | 15 | Memory operand, ones-complement, bit 14 is the sign |
| addr_fixed | input | 1 | 1 when the operand address is read-only memory |
| acc_q | output | 16 | Registered accumulator |
| wb_word | output | 15 | Memory write-back word |
| wb_en | output | 1 | Write-back enable, one cycle |
| ovf | output | 1 | Accumulator top bits differ |
| res_valid | output | 1 | Result of the previous cycle's operation is on the outputs |

## Verification
In an exchange to erasable memory, two things land on the same clock edge: the old accumulator is folded into the write-back word, and the new operand is loaded into the accumulator. The bench provokes this by exchanging while the accumulator sits in positive overflow and again in negative overflow. It judges the write-back sign against the old top bit and the new accumulator against the operand. Back-to-back operations with no idle gap then show that each result uses the freshly loaded accumulator, and that the overflow status follows each new value at once.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_LDC = 3'd2,
    OP_AND = 3'd3,
    OP_XCH = 3'd4
  } op_e;
endpackage

// File: rtl/oc_sext.sv
// Widen a ones-complement memory word by duplicating its sign bit.
module oc_sext #(
  parameter int DW = 15
) (
  input  logic [DW-1:0] word_i,
  output logic [DW:0]   wide_o
);
  always_comb wide_o = {word_i[DW-1], word_i};
endmodule

// File: rtl/oc_eac_adder.sv
// Ones-complement adder: the carry out of the top bit is fed back into bit 0.
module oc_eac_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;
  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/oc_wb_fold.sv
// Fold the wide accumulator into a memory word; the leftmost bit becomes the sign.
module oc_wb_fold #(
  parameter int DW = 15
) (
  input  logic [DW:0]   acc_i,
  output logic [DW-1:0] word_o
);
  always_comb word_o = {acc_i[DW], acc_i[DW-2:0]};
endmodule

// File: rtl/oc_acc_unit.sv
module oc_acc_unit #(
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] mem_word,
  input  logic          addr_fixed,
  output logic [DW:0]   acc_q,
  output logic [DW-1:0] wb_word,
  output logic          wb_en,
  output logic          ovf,
  output logic          res_valid
);
  import oc_pkg::*;

  localparam int AW = DW + 1;

  logic [AW-1:0] opnd_ext;
  logic [AW-1:0] add_sum;
  logic [AW-1:0] sub_sum;
  logic [DW-1:0] fold_word;
  logic [AW-1:0] acc_nxt;
  logic          wb_nxt;

  oc_sext #(.DW(DW)) u_sext (
    .word_i (mem_word),
    .wide_o (opnd_ext)
  );

  oc_eac_adder #(.W(AW)) u_add (
    .a_i   (acc_q),
    .b_i   (opnd_ext),
    .sum_o (add_sum)
  );

  oc_eac_adder #(.W(AW)) u_sub (
    .a_i   (acc_q),
    .b_i   (~opnd_ext),
    .sum_o (sub_sum)
  );

  oc_wb_fold #(.DW(DW)) u_fold (
    .acc_i  (acc_q),
    .word_o (fold_word)
  );

  always_comb begin
    acc_nxt = acc_q;
    wb_nxt  = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_ADD:  acc_nxt = add_sum;
        OP_SUB:  acc_nxt = sub_sum;
        OP_LDC:  acc_nxt = ~opnd_ext;
        OP_AND:  acc_nxt = acc_q & opnd_ext;
        OP_XCH: begin
          acc_nxt = opnd_ext;
          wb_nxt  = ~addr_fixed;
        end
        default: acc_nxt = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      wb_word   <= '0;
      wb_en     <= 1'b0;
      ovf       <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      acc_q     <= acc_nxt;
      wb_en     <= wb_nxt;
      ovf       <= acc_nxt[AW-1] ^ acc_nxt[AW-2];
      res_valid <= op_valid;
      if (wb_nxt) wb_word <= fold_word;
    end
  end
endmodule

// File: rtl/oc_acc_unit_chk.sv
module oc_acc_unit_chk #(
  parameter int DW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [DW-1:0] mem_word,
  input logic          addr_fixed,
  input logic [DW:0]   acc_q,
  input logic [DW-1:0] wb_word,
  input logic          wb_en,
  input logic          ovf,
  input logic          res_valid
);
  // R8
  ovf_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ovf == (acc_q[DW] ^ acc_q[DW-1]));

  // R10
  res_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R10
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && !wb_en));

  // R6
  fixed_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd4 && addr_fixed) |=> !wb_en);

  // R7
  erasable_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd4 && !addr_fixed) |=>
      (wb_en && wb_word[DW-1] == $past(acc_q[DW])
             && wb_word[DW-2:0] == $past(acc_q[DW-2:0])));

  // R4
  ldc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |=>
      (acc_q == ~{$past(mem_word[DW-1]), $past(mem_word)}));
endmodule

bind oc_acc_unit oc_acc_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .mem_word(mem_word), .addr_fixed(addr_fixed), .acc_q(acc_q),
  .wb_word(wb_word), .wb_en(wb_en), .ovf(ovf), .res_valid(res_valid)
);

// File: tb/sim_oc_acc_unit.sv
module sim_oc_acc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [14:0] mem_word = '0;
  logic        addr_fixed = 1'b0;
  logic [15:0] acc_q;
  logic [14:0] wb_word;
  logic        wb_en, ovf, res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] acc;
    logic        wen;
    logic [14:0] wword;
    logic        ov;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model_acc = '0;
  logic [15:0] last_acc = '0;

  always #2.5 clk = ~clk;

  oc_acc_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .mem_word(mem_word), .addr_fixed(addr_fixed), .acc_q(acc_q),
    .wb_word(wb_word), .wb_en(wb_en), .ovf(ovf), .res_valid(res_valid)
  );

  function automatic logic [15:0] widen(input logic [14:0] w);
    return {w[14], w};
  endfunction

  // Ones-complement sum as modular arithmetic over 2^16-1.
  function automatic logic [15:0] oc_sum(input logic [15:0] a, input logic [15:0] b);
    int unsigned t;
    t = int'(a) + int'(b);
    if (t > 32'd65535) t = t - 32'd65535;
    return t[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [14:0] m,
                       input logic fx, input string tag);
    exp_t e;
    logic [15:0] x;
    x       = widen(m);
    e.wen   = 1'b0;
    e.wword = 'x;
    e.tag   = tag;
    case (op)
      3'd0: e.acc = oc_sum(model_acc, x);
      3'd1: e.acc = oc_sum(model_acc, ~x);
      3'd2: e.acc = ~x;
      3'd3: e.acc = model_acc & x;
      3'd4: begin
        e.acc = x;
        if (!fx) begin
          e.wen   = 1'b1;
          e.wword = {model_acc[15], model_acc[13:0]};
        end
      end
      default: e.acc = model_acc;
    endcase
    e.ov      = e.acc[15] != e.acc[14];
    model_acc = e.acc;
    sb.push_back(e);
    op_valid   = 1'b1;
    op_code    = op;
    mem_word   = m;
    addr_fixed = fx;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0;
    op_code  = 3'd0;
    mem_word = 15'h7FFF;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected res_valid", 16'(res_valid), 16'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(acc_q == e.acc, e.tag, "acc_q", acc_q, e.acc);
          check(ovf == e.ov, "R8", "ovf", 16'(ovf), 16'(e.ov));
          check(wb_en == e.wen, e.tag, "wb_en", 16'(wb_en), 16'(e.wen));
          if (e.wen)
            check(wb_word == e.wword, "R7", "wb_word", 16'(wb_word), 16'(e.wword));
        end
      end else begin
        // R9: no operation, accumulator held and no write-back
        check(acc_q == last_acc && !wb_en, "R9", "idle hold", acc_q, last_acc);
      end
      last_acc = acc_q;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(acc_q == 16'd0, "R1", "acc_q", acc_q, 16'd0);
    check(!ovf && !wb_en && !res_valid, "R1", "flags",
          {13'd0, ovf, wb_en, res_valid}, 16'd0);
    idle(2);

    do_op(3'd2, 15'h7FFA, 1'b0, "R4");  // load complement of -5 -> +5
    do_op(3'd0, 15'h7FFE, 1'b0, "R2");  // +5 + (-1) with end-around carry
    do_op(3'd1, 15'h0007, 1'b0, "R3");  // 4 - 7 = -3
    do_op(3'd3, 15'h00FF, 1'b0, "R5");  // AND
    idle(3);
    do_op(3'd4, 15'h3FFF, 1'b1, "R6");  // exchange from fixed memory
    do_op(3'd0, 15'h3FFF, 1'b0, "R8");  // positive overflow state
    do_op(3'd4, 15'h1234, 1'b0, "R7");  // exchange, overflowed acc folded
    idle(1);
    // R8: chain through overflow back to the exact total
    do_op(3'd2, 15'h4000, 1'b0, "R4");
    do_op(3'd0, 15'h3FFF, 1'b0, "R8");
    do_op(3'd0, 15'h4001, 1'b0, "R8");
    do_op(3'd1, 15'h0001, 1'b0, "R8");
    // R9: reserved opcodes leave the accumulator alone
    do_op(3'd5, 15'h1111, 1'b0, "R9");
    do_op(3'd7, 15'h2222, 1'b0, "R9");
    // negative overflow, then exchange to erasable memory (R7)
    do_op(3'd2, 15'h3FFF, 1'b0, "R4");
    do_op(3'd0, 15'h4000, 1'b0, "R8");
    do_op(3'd4, 15'h0000, 1'b0, "R7");
    do_op(3'd4, 15'h5555, 1'b1, "R6");
    do_op(3'd1, 15'h7FFF, 1'b0, "R3");  // subtract negative zero
    idle(3);
    // R10: every issued operation produced exactly one result
    check(sb.size() == 0, "R10", "pending results", 16'(sb.size()), 16'd0);
    finish_run();
  end
endmodule